// File: doc/BRIEF.md
# Packet Buffer Memory Self-Test Engine

This engine checks a packet buffer RAM that is organised as 16-bit words. It drives the RAM through a synchronous single-port master interface: an address, write data, a write enable and returned read data. The RAM itself sits outside the block. A start pulse launches a run of four passes. In each pass the engine fills the whole memory with one data pattern and then reads every word back.

Each pass uses its own pattern. The first two patterns are derived from the byte address of the word, so an address that aliases onto another shows up as wrong data. The last two are complementary checkerboard constants, which expose bits stuck at either level and shorts between neighbouring bits. Every word that reads back wrong adds one to a saturating fault counter. The counter runs across all four passes and keeps its value after the run, until the next start clears it.

The buffer size defaults to 64 KiB and the counter width to 32 bits. Both are parameters.

Top module: `pktbuf_mbist`

## Requirements
- R1: After reset the engine is idle: busy low, done low, write enable low, fault count zero.
- R2: A start pulse while idle sets busy from the following cycle and clears the fault count to zero in that same cycle. The first access of the run is a write to word 0.
- R3: Each pass writes every word in ascending order from word 0, then reads every word in ascending order from word 0. With N words a run keeps busy high for exactly 8N+1 cycles.
- R4: The written data is chosen by pass number, with byte address = 2 × word index:
  - pass 1 writes the byte address;
  - pass 2 writes the byte address XOR (buffer bytes − 1);
  - pass 3 writes 0xAA55;
  - pass 4 writes 0x55AA.
- R5: Read data is taken one cycle after its address is presented and compared with the pattern of that pass and word. Each mismatching word adds one to the fault count, summed over all four passes.
- R6: The fault count saturates at 2^CNT_W − 1 and never wraps.
- R7: When the run ends, done is high for exactly one cycle, in the same cycle that busy falls. The fault count is final in that cycle and then holds until the next start.
- R8: A start pulse while busy is ignored: the run length, the access sequence and the fault count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a run |
| mem_addr_o | output | WORD_AW | Word address to the RAM |
| mem_wdata_o | output | 16 | Write data to the RAM |
| mem_we_o | output | 1 | Write enable; low means read |
| mem_rdata_i | input | 16 | RAM read data, one cycle after the address |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fault_cnt_o | output | CNT_W | Saturating count of mismatching words |

## Verification
Faults in the sequencer show up at the RAM port within one cycle. An address that is skipped or repeated, a pass taken out of order, or a write enable in the wrong phase each shows up as a write or read address, or a data value, that departs from the ascending sweep and the pattern table. A wrong compare alignment or a counter fault is hidden until done. It then appears as a fault total that differs from the one computed from the injected stuck bits. A bad end-of-run sequence appears as a run length other than 8N+1 or a done pulse wider than one cycle. The testbench uses a 128-word buffer and an 8-bit counter. This keeps a full run short and lets saturation be reached.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int MB_DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DRAIN
  } mbist_state_e;

  // Data value for a given pass (0..3) and 16-bit byte address.
  function automatic logic [MB_DATA_W-1:0] mbist_pattern(
    input logic [1:0]           pass,
    input logic [MB_DATA_W-1:0] byte_addr,
    input logic [MB_DATA_W-1:0] size_mask
  );
    logic [MB_DATA_W-1:0] v;
    unique case (pass)
      2'd0:    v = byte_addr;
      2'd1:    v = byte_addr ^ size_mask;
      2'd2:    v = 16'hAA55;
      default: v = 16'h55AA;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int WORDS   = 32768,
  parameter int WORD_AW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic [WORD_AW-1:0] addr_o,
  output logic [1:0]         pass_o,
  output logic               we_o,
  output logic               rd_issue_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               launch_o
);

  localparam logic [WORD_AW-1:0] LAST_WORD = WORD_AW'(WORDS - 1);

  mbist_state_e       state_q;
  logic [WORD_AW-1:0] addr_q;
  logic [1:0]         pass_q;
  logic               done_q;
  logic               at_last;

  assign at_last    = (addr_q == LAST_WORD);
  assign launch_o   = (state_q == ST_IDLE) && start_i;
  assign we_o       = (state_q == ST_WRITE);
  assign rd_issue_o = (state_q == ST_READ);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign addr_o     = addr_q;
  assign pass_o     = pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pass_q  <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_DRAIN);
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_WRITE;
            addr_q  <= '0;
            pass_q  <= 2'd0;
          end
        end
        ST_WRITE: begin
          if (at_last) begin
            addr_q  <= '0;
            state_q <= ST_READ;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_READ: begin
          if (at_last) begin
            addr_q <= '0;
            if (pass_q == 2'd3) begin
              state_q <= ST_DRAIN;
            end else begin
              pass_q  <= pass_q + 1'b1;
              state_q <= ST_WRITE;
            end
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (addr_o == '0 && we_o && pass_o == 2'd0));

  // R3
  pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (pass_o == $past(pass_o) || pass_o == $past(pass_o) + 2'd1));

  // R7
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && start_i && !at_last) |=> (we_o && addr_o == $past(addr_o) + 1'b1));

endmodule

// File: rtl/mbist_patgen.sv
module mbist_patgen
  import mbist_pkg::*;
#(
  parameter int MEM_BYTES = 65536,
  parameter int WORD_AW   = $clog2(MEM_BYTES / 2)
) (
  input  logic [WORD_AW-1:0]   addr_i,
  input  logic [1:0]           pass_i,
  output logic [MB_DATA_W-1:0] pattern_o
);

  localparam logic [MB_DATA_W-1:0] SIZE_MASK = MB_DATA_W'(MEM_BYTES - 1);

  logic [MB_DATA_W-1:0] byte_addr;

  assign byte_addr = MB_DATA_W'({addr_i, 1'b0});
  assign pattern_o = mbist_pattern(pass_i, byte_addr, SIZE_MASK);

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
  import mbist_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 rd_issue_i,
  input  logic [MB_DATA_W-1:0] exp_i,
  input  logic [MB_DATA_W-1:0] rdata_i,
  output logic                 miss_o,
  output logic [CNT_W-1:0]     count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                 vld_q;
  logic [MB_DATA_W-1:0] exp_q;
  logic [CNT_W-1:0]     cnt_q;

  assign miss_o  = vld_q && (rdata_i != exp_q);
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      exp_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= rd_issue_i;
      exp_q <= exp_i;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (miss_o && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && !clear_i) |=> (count_o == CNT_MAX));

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

  // R5
  miss_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_o && !clear_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/pktbuf_mbist.sv
module pktbuf_mbist
  import mbist_pkg::*;
#(
  parameter int MEM_BYTES = 65536,
  parameter int CNT_W     = 32,
  parameter int WORDS     = MEM_BYTES / 2,
  parameter int WORD_AW   = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output logic [WORD_AW-1:0]   mem_addr_o,
  output logic [MB_DATA_W-1:0] mem_wdata_o,
  output logic                 mem_we_o,
  input  logic [MB_DATA_W-1:0] mem_rdata_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [CNT_W-1:0]     fault_cnt_o
);

  logic [WORD_AW-1:0]   seq_addr;
  logic [1:0]           seq_pass;
  logic                 seq_we;
  logic                 seq_rd;
  logic                 seq_launch;
  logic [MB_DATA_W-1:0] cur_pattern;
  logic                 word_miss;

  mbist_seq #(.WORDS(WORDS), .WORD_AW(WORD_AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .addr_o     (seq_addr),
    .pass_o     (seq_pass),
    .we_o       (seq_we),
    .rd_issue_o (seq_rd),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .launch_o   (seq_launch)
  );

  mbist_patgen #(.MEM_BYTES(MEM_BYTES), .WORD_AW(WORD_AW)) u_pat (
    .addr_i    (seq_addr),
    .pass_i    (seq_pass),
    .pattern_o (cur_pattern)
  );

  mbist_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (seq_launch),
    .rd_issue_i (seq_rd),
    .exp_i      (cur_pattern),
    .rdata_i    (mem_rdata_i),
    .miss_o     (word_miss),
    .count_o    (fault_cnt_o)
  );

  assign mem_addr_o  = seq_addr;
  assign mem_wdata_o = cur_pattern;
  assign mem_we_o    = seq_we;

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(fault_cnt_o));

  // R5
  idle_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |-> !word_miss);

  // R3
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_we_o);

endmodule

// File: tb/pktbuf_mbist_tb.sv
module pktbuf_mbist_tb;

  localparam int MEM_BYTES = 256;
  localparam int WORDS     = MEM_BYTES / 2;
  localparam int AW        = 7;
  localparam int CNT_W     = 8;
  localparam int CMAX      = 255;
  localparam int RUN_CYC   = 8 * WORDS + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [AW-1:0]    mem_addr;
  logic [15:0]      mem_wdata;
  logic             mem_we;
  logic [15:0]      mem_rdata;
  logic             busy;
  logic             done;
  logic [CNT_W-1:0] fcnt;

  int vectors = 0;
  int fails   = 0;

  bit          f_all = 1'b0;
  bit          f_en  = 1'b0;
  int          f_addr = 0;
  logic [15:0] f_and = 16'h0;
  logic [15:0] f_or  = 16'h0;

  int wpass, widx, ridx;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  pktbuf_mbist #(.MEM_BYTES(MEM_BYTES), .CNT_W(CNT_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .busy_o      (busy),
    .done_o      (done),
    .fault_cnt_o (fcnt)
  );

  function automatic logic [15:0] want_pat(int p, int w);
    case (p)
      0:       return 16'(w * 2);
      1:       return 16'(w * 2) ^ 16'(MEM_BYTES - 1);
      2:       return 16'hAA55;
      default: return 16'h55AA;
    endcase
  endfunction

  function automatic logic [15:0] corrupt(logic [15:0] v, int w);
    if (f_all || (f_en && w == f_addr)) return (v & ~f_and) | f_or;
    return v;
  endfunction

  function automatic int want_faults();
    int n = 0;
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < WORDS; w++)
        if (corrupt(want_pat(p, w), w) != want_pat(p, w)) n++;
    return (n > CMAX) ? CMAX : n;
  endfunction

  // Memory model with one-cycle read latency and read-side fault injection
  logic [15:0] ram [WORDS];
  initial for (int i = 0; i < WORDS; i++) ram[i] = 16'h0;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= corrupt(ram[mem_addr], int'(mem_addr));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Access-order and pattern monitor
  always @(negedge clk) begin
    if (mon_on && busy) begin
      if (mem_we) begin
        chk(int'(mem_addr) == widx, "R3", "write address", mem_addr, widx);
        chk(mem_wdata == want_pat(wpass, widx), "R4", "write data",
            mem_wdata, want_pat(wpass, widx));
        widx++;
        if (widx == WORDS) begin
          widx = 0;
          wpass++;
        end
      end else if (ridx < 4 * WORDS) begin
        chk(int'(mem_addr) == ridx % WORDS, "R3", "read address", mem_addr, ridx % WORDS);
        ridx++;
      end
    end
  end

  task automatic run(input int poke, input string tag);
    int cyc;
    int expc;
    logic [CNT_W-1:0] held;
    expc  = want_faults();
    wpass = 0; widx = 0; ridx = 0;
    mon_on = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
    chk(fcnt == 0, "R2", {tag, " count cleared"}, fcnt, 0);
    cyc = 1;
    while (!done && cyc < RUN_CYC + 50) begin
      @(negedge clk);
      start = (cyc == poke);
      if (busy) cyc++;
    end
    start = 1'b0;
    chk(cyc == RUN_CYC, "R3", {tag, " busy cycles"}, cyc, RUN_CYC);
    chk(done && !busy, "R7", {tag, " done with busy low"}, {done, busy}, 2);
    chk(int'(fcnt) == expc, "R5", {tag, " fault count"}, fcnt, expc);
    chk(wpass == 4 && ridx == 4 * WORDS, "R3", {tag, " passes completed"}, wpass, 4);
    held = fcnt;
    @(negedge clk);
    chk(!done, "R7", {tag, " done width"}, done, 0);
    repeat (5) @(negedge clk);
    chk(fcnt == held && !busy, "R7", {tag, " count holds"}, fcnt, held);
    mon_on = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mem_we && fcnt == 0, "R1", "reset outputs",
        {busy, done, mem_we, fcnt}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && fcnt == 0, "R1", "idle after reset", busy, 0);

    // clean memory: no faults (R5)
    run(-1, "clean");

    // single word, bit 0 stuck high (R5)
    f_en = 1'b1; f_addr = 5; f_or = 16'h0001;
    run(-1, "stuck1");

    // last word, bit 15 stuck low, start poked mid-run (R8)
    f_addr = WORDS - 1; f_or = 16'h0; f_and = 16'h8000;
    run(300, "R8_poke");

    // every word reads zero: saturation (R6)
    f_en = 1'b0; f_all = 1'b1; f_and = 16'hFFFF;
    run(-1, "R6_sat");

    // clean run after saturation clears the count (R2)
    f_all = 1'b0; f_and = 16'h0;
    run(-1, "R2_clear");

    // every word bit 8 stuck high, early poke (R6, R8)
    f_all = 1'b1; f_or = 16'h0100;
    run(5, "R6_or");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule